// File: doc/BRIEF.md
# Segmented Instruction Prefetch Queue

This block runs ahead of an execution consumer and keeps a small byte queue of instruction bytes filled. It holds the current code segment and fetch offset, and it forms each memory address as the segment shifted left by four bits plus the offset. The sum is truncated to 20 bits. Fetching goes on while the consumer is still busy with earlier bytes, so fetch and execute overlap. The consumer has no memory path of its own and takes bytes only from the queue.

Memory is reached through a request/response port. A request is a valid/ready handshake: once the block raises `mem_req_valid_o`, it holds the request and its address steady until `mem_req_ready_i` is seen high. The only exception is a flush, which may withdraw or replace a request that has not been accepted. At most one request is outstanding at a time. Queue space is reserved before a request is issued, so the response port has no back-pressure. The consumer side is also valid/ready: a byte moves on every cycle in which both `pop_valid_o` and `pop_ready_i` are high. A flush pulse carries a new segment and offset, drops all queued bytes, and restarts fetching from the new location.

Top module: `seg_prefetch_unit`

## Requirements
- R1: After reset the queue is empty (`level_o` = 0, `pop_valid_o` = 0). The first request is a word fetch (`mem_req_byte_o` = 0) from segment FFFFh, offset 0000h, which is physical address FFFF0h.
- R2: Every request address equals (segment × 16 + offset) mod 2^20. A carry out of bit 19 is dropped.
- R3: At an even offset the block requests a word (`mem_req_byte_o` = 0). At an odd offset it requests a single byte (`mem_req_byte_o` = 1). A word response puts the byte at the lower address in bits 7:0, and that byte is queued first. A byte response carries its byte in bits 7:0.
- R4: A request is raised exactly when no request is outstanding and at least 2 queue bytes are free. The queue never holds more than 6 bytes.
- R5: The fetch offset advances by the number of bytes written into the queue. It wraps at 16 bits within the same segment.
- R6: `pop_valid_o` is high exactly when the queue is not empty. Popped bytes come out in consecutive address order.
- R7: A flush empties the queue at the next clock edge. Fetching then restarts at the new segment and offset.
- R8: A response to a request accepted before or during a flush is discarded. No new request is raised until that response has returned.
- R9: A request that is not accepted keeps its valid, address and size unchanged on the next cycle unless a flush intervenes.
- R10: `level_o` reports the number of queued bytes after each edge: previous level, plus bytes written, minus 1 for a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Flush and reload pulse |
| flush_seg_i | input | 16 | New code segment on flush |
| flush_ip_i | input | 16 | New fetch offset on flush |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_addr_o | output | 20 | Physical request address |
| mem_req_byte_o | output | 1 | 1 = single byte, 0 = 16-bit word |
| mem_rsp_valid_i | input | 1 | Response data valid |
| mem_rsp_data_i | input | 16 | Response data, lower address in bits 7:0 |
| pop_valid_o | output | 1 | Queue holds a byte |
| pop_ready_i | input | 1 | Consumer takes the head byte |
| pop_data_o | output | 8 | Head byte of the queue |
| level_o | output | 3 | Queue occupancy in bytes |

## Verification
A wrong fetch offset or segment does not show at the request port as a visible fault. It surfaces as the wrong byte at `pop_data_o` on the first pop after the bad response lands, which is typically two to four cycles later. A stale response that is wrongly accepted after a flush shows the same way, and it also raises `level_o` one cycle too early. A wrong occupancy count shows at once, because the request gate and `level_o` no longer match the count of bytes written minus bytes popped. That mismatch is visible on the cycle after the faulty edge.

// File: rtl/seg_pfq_pkg.sv
package seg_pfq_pkg;
  localparam int unsigned DEF_QDEPTH     = 6;
  localparam int unsigned DEF_SEG_W      = 16;
  localparam int unsigned DEF_OFF_W      = 16;
  localparam int unsigned DEF_ADDR_W     = 20;
  localparam int unsigned DEF_SEG_SHIFT  = 4;
  localparam int unsigned DEF_BUS_W      = 16;
  localparam int unsigned DEF_FETCH_ROOM = 2;

  typedef enum logic {
    FETCH_WORD = 1'b0,
    FETCH_BYTE = 1'b1
  } fetch_kind_e;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pfq_pkg::*;
#(
  parameter int unsigned SEG_W     = DEF_SEG_W,
  parameter int unsigned OFF_W     = DEF_OFF_W,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned SEG_SHIFT = DEF_SEG_SHIFT
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] phys_o
);
  // Base is the segment moved up by SEG_SHIFT; the sum keeps ADDR_W bits only.
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] disp;

  always_comb begin
    base   = ADDR_W'(seg_i) << SEG_SHIFT;
    disp   = ADDR_W'(off_i);
    phys_o = base + disp;
  end
endmodule

// File: rtl/seg_byte_queue.sv
module seg_byte_queue
  import seg_pfq_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_QDEPTH,
  parameter int unsigned DW    = 8,
  parameter int unsigned LANES = DEF_BUS_W / 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1),
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic [CNT_W-1:0]    push_cnt_i,
  input  logic [LANES*DW-1:0] push_data_i,
  input  logic                pop_i,
  output logic [DW-1:0]       head_o,
  output logic [LVL_W-1:0]    level_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q;
  logic [LVL_W-1:0] lvl_q;
  logic             pop_eff;

  function automatic logic [PTR_W-1:0] slot(input int base, input int k);
    return PTR_W'((base + k) % int'(DEPTH));
  endfunction

  assign pop_eff = pop_i && (lvl_q != '0);
  assign head_o  = mem_q[rd_q];
  assign level_o = lvl_q;

  // Pointer and occupancy: clear wins over push and pop.
  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (pop_eff) rd_q <= slot(int'(rd_q), 1);
      lvl_q <= LVL_W'(int'(lvl_q) + int'(push_cnt_i) - (pop_eff ? 1 : 0));
    end
  end

  // Lane k of the incoming word lands k slots past the current tail.
  always_ff @(posedge clk) begin
    for (int k = 0; k < int'(LANES); k++) begin
      if (!clr_i && (k < int'(push_cnt_i)))
        mem_q[slot(int'(rd_q) + int'(lvl_q), k)] <= push_data_i[k*DW +: DW];
    end
  end
endmodule

// File: rtl/seg_fetch_ctrl.sv
module seg_fetch_ctrl
  import seg_pfq_pkg::*;
#(
  parameter int unsigned QDEPTH     = DEF_QDEPTH,
  parameter int unsigned SEG_W      = DEF_SEG_W,
  parameter int unsigned OFF_W      = DEF_OFF_W,
  parameter int unsigned BUS_W      = DEF_BUS_W,
  parameter int unsigned FETCH_ROOM = DEF_FETCH_ROOM,
  parameter logic [SEG_W-1:0] RST_SEG = '1,
  parameter logic [OFF_W-1:0] RST_IP  = '0,
  localparam int unsigned LANES = BUS_W / 8,
  localparam int unsigned LVL_W = $clog2(QDEPTH + 1),
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [SEG_W-1:0] flush_seg_i,
  input  logic [OFF_W-1:0] flush_ip_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             req_ready_i,
  input  logic             rsp_valid_i,
  input  logic [BUS_W-1:0] rsp_data_i,
  output logic             req_valid_o,
  output logic             req_byte_o,
  output logic [SEG_W-1:0] seg_o,
  output logic [OFF_W-1:0] off_o,
  output logic [CNT_W-1:0] push_cnt_o,
  output logic [BUS_W-1:0] push_data_o
);
  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;
  logic             pending_q;
  logic             stale_q;
  fetch_kind_e      kind;
  logic             fire;
  logic             rsp_hit;
  logic             fresh;

  // Misaligned offset fetches one byte so later fetches fall on word bounds.
  assign kind        = off_q[0] ? FETCH_BYTE : FETCH_WORD;
  assign req_byte_o  = (kind == FETCH_BYTE);
  assign req_valid_o = !pending_q &&
                       ((int'(QDEPTH) - int'(level_i)) >= int'(FETCH_ROOM));
  assign fire        = req_valid_o && req_ready_i;
  assign rsp_hit     = rsp_valid_i && pending_q;
  assign fresh       = rsp_hit && !stale_q && !flush_i;
  assign push_cnt_o  = !fresh ? '0 :
                       (kind == FETCH_BYTE) ? CNT_W'(1) : CNT_W'(LANES);
  assign push_data_o = rsp_data_i;
  assign seg_o       = seg_q;
  assign off_o       = off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q     <= RST_SEG;
      off_q     <= RST_IP;
      pending_q <= 1'b0;
      stale_q   <= 1'b0;
    end else begin
      if (flush_i) begin
        seg_q <= flush_seg_i;
        off_q <= flush_ip_i;
      end else begin
        off_q <= off_q + OFF_W'(push_cnt_o);
      end

      if (fire)         pending_q <= 1'b1;
      else if (rsp_hit) pending_q <= 1'b0;

      // A response still owed at flush time belongs to the old stream.
      if (flush_i)      stale_q <= (pending_q && !rsp_valid_i) || fire;
      else if (rsp_hit) stale_q <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_prefetch_unit.sv
module seg_prefetch_unit
  import seg_pfq_pkg::*;
#(
  parameter int unsigned QDEPTH     = DEF_QDEPTH,
  parameter int unsigned SEG_W      = DEF_SEG_W,
  parameter int unsigned OFF_W      = DEF_OFF_W,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned SEG_SHIFT  = DEF_SEG_SHIFT,
  parameter int unsigned BUS_W      = DEF_BUS_W,
  parameter int unsigned FETCH_ROOM = DEF_FETCH_ROOM,
  parameter logic [SEG_W-1:0] RST_SEG = '1,
  parameter logic [OFF_W-1:0] RST_IP  = '0,
  localparam int unsigned LANES = BUS_W / 8,
  localparam int unsigned LVL_W = $clog2(QDEPTH + 1),
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [SEG_W-1:0]  flush_seg_i,
  input  logic [OFF_W-1:0]  flush_ip_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic              mem_req_byte_o,
  input  logic              mem_rsp_valid_i,
  input  logic [BUS_W-1:0]  mem_rsp_data_i,
  output logic              pop_valid_o,
  input  logic              pop_ready_i,
  output logic [7:0]        pop_data_o,
  output logic [LVL_W-1:0]  level_o
);
  logic [SEG_W-1:0] cur_seg;
  logic [OFF_W-1:0] cur_off;
  logic [CNT_W-1:0] push_cnt;
  logic [BUS_W-1:0] push_data;
  logic [LVL_W-1:0] level;
  logic             pop_fire;

  assign pop_valid_o = (level != '0);
  assign pop_fire    = pop_valid_o && pop_ready_i;
  assign level_o     = level;

  seg_fetch_ctrl #(
    .QDEPTH(QDEPTH), .SEG_W(SEG_W), .OFF_W(OFF_W), .BUS_W(BUS_W),
    .FETCH_ROOM(FETCH_ROOM), .RST_SEG(RST_SEG), .RST_IP(RST_IP)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .flush_seg_i (flush_seg_i),
    .flush_ip_i  (flush_ip_i),
    .level_i     (level),
    .req_ready_i (mem_req_ready_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .rsp_data_i  (mem_rsp_data_i),
    .req_valid_o (mem_req_valid_o),
    .req_byte_o  (mem_req_byte_o),
    .seg_o       (cur_seg),
    .off_o       (cur_off),
    .push_cnt_o  (push_cnt),
    .push_data_o (push_data)
  );

  seg_addr_gen #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)
  ) u_agen (
    .seg_i  (cur_seg),
    .off_i  (cur_off),
    .phys_o (mem_req_addr_o)
  );

  seg_byte_queue #(
    .DEPTH(QDEPTH), .DW(8), .LANES(LANES)
  ) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (flush_i),
    .push_cnt_i  (push_cnt),
    .push_data_i (push_data),
    .pop_i       (pop_fire),
    .head_o      (pop_data_o),
    .level_o     (level)
  );
endmodule

// File: rtl/seg_prefetch_unit_chk.sv
module seg_prefetch_unit_chk #(
  parameter int unsigned QDEPTH = 6,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned LVL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_i,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic              mem_req_byte_o,
  input logic              pop_valid_o,
  input logic [LVL_W-1:0]  level_o
);
  // R4
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= LVL_W'(QDEPTH));

  // R4
  fetch_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> (level_o <= LVL_W'(QDEPTH - 2)));

  // R3
  fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> (mem_req_byte_o == mem_req_addr_o[0]));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i && !flush_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_byte_o)));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (level_o == '0 && !pop_valid_o));

  // R8
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);
endmodule

bind seg_prefetch_unit seg_prefetch_unit_chk u_chk (.*);

// File: tb/seg_prefetch_unit_tb.sv
module seg_prefetch_unit_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic [15:0] flush_seg_i = '0;
  logic [15:0] flush_ip_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [19:0] mem_req_addr_o;
  logic        mem_req_byte_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [15:0] mem_rsp_data_i = '0;
  logic        pop_valid_o;
  logic        pop_ready_i = 1'b0;
  logic [7:0]  pop_data_o;
  logic [2:0]  level_o;

  seg_prefetch_unit u_dut (.*);

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(input logic [19:0] a);
    return (a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]}) + 8'h3C;
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return ({4'h0, s} << 4) + {4'h0, o};
  endfunction

  // Bench model state
  logic        busy = 1'b0, stale = 1'b0, rb = 1'b0;
  logic [19:0] ra = '0;
  int          lat = 0, cyc = 0, exp_level = 0, p_push = 0;
  logic        p_flush = 1'b0, p_pop = 1'b0, p_req_wait = 1'b0, p_byte = 1'b0;
  logic [19:0] p_addr = '0;
  logic [15:0] exp_seg = 16'hFFFF, exp_ip = 16'h0000;

  task automatic step(input logic do_fl, input logic [15:0] s, input logic [15:0] ip,
                      input int mode);
    logic pr;
    @(negedge clk);
    cyc++;
    if (p_flush) exp_level = 0;
    else exp_level = exp_level + p_push - (p_pop ? 1 : 0);
    // R10 occupancy, R6 pop gating, R4 and R8 request gating
    chk("R10 level", 32'(level_o), 32'(exp_level));
    chk("R6 pop valid", 32'(pop_valid_o), 32'(exp_level != 0));
    chk("R4 R8 request gate", 32'(mem_req_valid_o), 32'(!busy && exp_level <= 4));
    if (p_flush) chk("R7 flush empties", 32'(level_o), 32'd0);
    if (p_req_wait && !p_flush) begin
      chk("R9 hold valid", 32'(mem_req_valid_o), 32'd1);
      chk("R9 hold addr", 32'(mem_req_addr_o), 32'(p_addr));
      chk("R9 hold size", 32'(mem_req_byte_o), 32'(p_byte));
    end
    // memory model
    p_push = 0;
    mem_rsp_valid_i = 1'b0;
    if (busy) begin
      if (lat == 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = rb ? {8'h00, mb(ra)} : {mb(ra + 20'd1), mb(ra)};
        busy = 1'b0;
        if (!stale) p_push = rb ? 1 : 2;
        stale = 1'b0;
      end else lat--;
    end
    mem_req_ready_i = !busy && ((mode == 0) || ((cyc % (mode + 2)) != 0));
    p_req_wait = mem_req_valid_o && !mem_req_ready_i;
    p_addr = mem_req_addr_o;
    p_byte = mem_req_byte_o;
    if (mem_req_valid_o && mem_req_ready_i) begin
      chk("R3 size follows offset parity", 32'(mem_req_byte_o), 32'(mem_req_addr_o[0]));
      busy = 1'b1;
      lat  = (cyc * (mode + 1)) % 4;
      ra   = mem_req_addr_o;
      rb   = mem_req_byte_o;
    end
    // consumer
    case (mode)
      0: pr = 1'b1;
      1: pr = (cyc % 2) == 0;
      2: pr = (cyc % 5) != 0;
      default: pr = (cyc % 16) >= 10;
    endcase
    pop_ready_i = pr;
    p_pop = pop_valid_o && pr;
    if (p_pop) begin
      // R2 R3 R5 R6 R8: byte must match the model memory at the expected address
      chk("R2 R3 R5 R6 R8 pop byte", 32'(pop_data_o), 32'(mb(phys(exp_seg, exp_ip))));
      exp_ip = exp_ip + 16'd1;
    end
    // flush
    flush_i = do_fl;
    flush_seg_i = s;
    flush_ip_i = ip;
    p_flush = do_fl;
    if (do_fl) begin
      exp_seg = s;
      exp_ip  = ip;
      if (busy) stale = 1'b1;
    end
  endtask

  logic [15:0] tseg [9] = '{16'hFFFF, 16'hFFFF, 16'h1234, 16'h0000, 16'h0FFF,
                            16'h1000, 16'hF000, 16'hABCD, 16'h0001};
  logic [15:0] tip  [9] = '{16'h000C, 16'hFFF9, 16'hFFFB, 16'h0001, 16'h0010,
                            16'h0000, 16'hFFFF, 16'h7777, 16'hFFFE};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and first fetch
    chk("R1 level", 32'(level_o), 32'd0);
    chk("R1 pop valid", 32'(pop_valid_o), 32'd0);
    chk("R1 req valid", 32'(mem_req_valid_o), 32'd1);
    chk("R1 req addr", 32'(mem_req_addr_o), 32'h000FFFF0);
    chk("R1 req size", 32'(mem_req_byte_o), 32'd0);
    for (int i = 0; i < 40; i++) step(1'b0, 16'h0, 16'h0, 3);
    for (int t = 0; t < 9; t++) begin
      for (int m = 0; m < 4; m++) begin
        int len;
        len = 12 + ((t * 5 + m * 7) % 29);
        step(1'b1, tseg[t], tip[t], m);
        for (int i = 0; i < len; i++) step(1'b0, 16'h0, 16'h0, m);
      end
    end
    for (int i = 0; i < 20; i++) step(1'b0, 16'h0, 16'h0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule